// File: doc/BRIEF.md
# Predicated Vector Integer Multiply-Add Slice

This block is one execution slice of a wide integer vector unit. Each operation takes a 512-bit destination operand and two 512-bit source operands. It splits them into lanes and, in every lane, multiplies two of the operands and adds the third. A per-lane predicate decides whether the new value or the untouched destination value reaches the result. The lanes are either sixteen 32-bit lanes or eight 64-bit lanes, picked for each operation.

A two-bit form code sets the roles of the operands: which of them are the multiplier inputs and which is the addend. The slice is fully pipelined. It accepts a new operation on every clock and returns each result a fixed four clocks after it was issued, so an issuing stage can track results with a plain delay line.

Top module: `simd_fma_unit`

## Requirements
- R1: `outValid` rises exactly four rising clock edges after the edge that samples `inValid` high, and only then. While `rstN` is low and on the first edge after reset, `outValid` is 0.
- R2: With `widthSel`=0, lane i (i = 0..15) occupies bits [32i+31:32i]. Its result is the product and sum wrapped modulo 2^32, with no carry into lane i+1.
- R3: With `widthSel`=1, lane i (i = 0..7) occupies bits [64i+63:64i]. Its result is wrapped modulo 2^64.
- R4: `formSel`=0 gives lane result = dst × src3 + src2.
- R5: `formSel`=1 gives lane result = src2 × dst + src3.
- R6: `formSel`=2 gives lane result = src2 × src3 + dst.
- R7: `formSel`=3 behaves exactly like `formSel`=0.
- R8: With `widthSel`=0, a lane whose `laneMask` bit i is 0 outputs its destination operand unchanged. A lane whose bit is 1 outputs the computed value.
- R9: With `widthSel`=1, 64-bit lane i is enabled by `laneMask` bit i. Bits 15:8 have no effect on the result.
- R10: Operations issued on consecutive clocks each return their own result, computed with their own width, form and mask, in issue order and on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the valid pipeline |
| inValid | input | 1 | Issue strobe for the operands on this edge |
| widthSel | input | 1 | 0: sixteen 32-bit lanes, 1: eight 64-bit lanes |
| formSel | input | 2 | Operand role code (0..3) |
| opDst | input | 512 | Destination operand, also the pass-through value |
| opSrc2 | input | 512 | Second source operand |
| opSrc3 | input | 512 | Third source operand |
| laneMask | input | 16 | Per-lane predicate |
| outValid | output | 1 | Result strobe |
| outData | output | 512 | Merged result |

## Verification
In one cycle the slice can hand a finished result to the output while it takes in a new operation whose width, form and mask all differ. It does this because each pipeline stage keeps its own copy of the width and of the lane enables. The bench provokes this by streaming operations on back-to-back clocks with mode, form and mask changing every time. It judges every result, as it emerges, against a model of the operation issued four clocks earlier. A second overlap is the predicate and the arithmetic acting in the same lane. Partial masks in both widths, with the upper mask bits set in 64-bit mode, show whether only the enabled lanes changed.

// File: rtl/simd_fma_pkg.sv
package simd_fma_pkg;
  parameter int DATA_W   = 512;
  parameter int NARROW_W = 32;
  parameter int N_STAGES = 4;
  localparam int WIDE_W    = 2 * NARROW_W;
  localparam int N_NARROW  = DATA_W / NARROW_W;
  localparam int N_WIDE    = DATA_W / WIDE_W;

  typedef enum logic [1:0] {
    FORM_DST_S3_S2 = 2'd0,
    FORM_S2_DST_S3 = 2'd1,
    FORM_S2_S3_DST = 2'd2,
    FORM_ALIAS0    = 2'd3
  } form_e;

  typedef struct packed {
    logic [N_STAGES-1:0] load;
    logic                fire;
  } pipe_ctrl_t;
endpackage

// File: rtl/simd_fma_ctrl.sv
module simd_fma_ctrl
  import simd_fma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output pipe_ctrl_t ctrl
);
  logic [N_STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[N_STAGES-2:0], inValid};
  end

  always_comb begin
    ctrl.load = {vPipe[N_STAGES-2:0], inValid};
    ctrl.fire = vPipe[N_STAGES-1];
  end
endmodule

// File: rtl/simd_fma_datapath.sv
module simd_fma_datapath
  import simd_fma_pkg::*;
(
  input  logic              clk,
  input  pipe_ctrl_t        ctrl,
  input  logic              widthSel,
  input  logic [1:0]        formSel,
  input  logic [DATA_W-1:0] opDst,
  input  logic [DATA_W-1:0] opSrc2,
  input  logic [DATA_W-1:0] opSrc3,
  input  logic [15:0]       laneMask,
  output logic [DATA_W-1:0] resData
);
  // stage 0 comb: operand roles and chunk enables
  logic [DATA_W-1:0]   mulA, mulB, addC;
  logic [N_NARROW-1:0] chunkEn;

  always_comb begin
    case (form_e'(formSel))
      FORM_S2_DST_S3: begin mulA = opSrc2; mulB = opDst;  addC = opSrc3; end
      FORM_S2_S3_DST: begin mulA = opSrc2; mulB = opSrc3; addC = opDst;  end
      default:        begin mulA = opDst;  mulB = opSrc3; addC = opSrc2; end
    endcase
  end

  for (genvar j = 0; j < N_NARROW; j++) begin : g_en
    assign chunkEn[j] = widthSel ? laneMask[j/2] : laneMask[j];
  end

  // stage 1 registers
  logic [DATA_W-1:0]   aS1, bS1, cS1, dS1;
  logic [N_NARROW-1:0] enS1;
  logic                wS1;
  always_ff @(posedge clk) begin
    if (ctrl.load[0]) begin
      aS1 <= mulA; bS1 <= mulB; cS1 <= addC; dS1 <= opDst;
      enS1 <= chunkEn; wS1 <= widthSel;
    end
  end

  // stage 1 comb: lane products, both widths
  logic [DATA_W-1:0] prodN, prodW, prodSel;
  for (genvar j = 0; j < N_NARROW; j++) begin : g_pn
    assign prodN[j*NARROW_W +: NARROW_W] =
      aS1[j*NARROW_W +: NARROW_W] * bS1[j*NARROW_W +: NARROW_W];
  end
  for (genvar k = 0; k < N_WIDE; k++) begin : g_pw
    assign prodW[k*WIDE_W +: WIDE_W] =
      aS1[k*WIDE_W +: WIDE_W] * bS1[k*WIDE_W +: WIDE_W];
  end
  assign prodSel = wS1 ? prodW : prodN;

  // stage 2 registers
  logic [DATA_W-1:0]   pS2, cS2, dS2;
  logic [N_NARROW-1:0] enS2;
  logic                wS2;
  always_ff @(posedge clk) begin
    if (ctrl.load[1]) begin
      pS2 <= prodSel; cS2 <= cS1; dS2 <= dS1; enS2 <= enS1; wS2 <= wS1;
    end
  end

  // stage 2 comb: lane sums
  logic [DATA_W-1:0] sumN, sumW, sumSel;
  for (genvar j = 0; j < N_NARROW; j++) begin : g_sn
    assign sumN[j*NARROW_W +: NARROW_W] =
      pS2[j*NARROW_W +: NARROW_W] + cS2[j*NARROW_W +: NARROW_W];
  end
  for (genvar k = 0; k < N_WIDE; k++) begin : g_sw
    assign sumW[k*WIDE_W +: WIDE_W] =
      pS2[k*WIDE_W +: WIDE_W] + cS2[k*WIDE_W +: WIDE_W];
  end
  assign sumSel = wS2 ? sumW : sumN;

  // stage 3 registers
  logic [DATA_W-1:0]   sS3, dS3;
  logic [N_NARROW-1:0] enS3;
  always_ff @(posedge clk) begin
    if (ctrl.load[2]) begin
      sS3 <= sumSel; dS3 <= dS2; enS3 <= enS2;
    end
  end

  // stage 3 comb: predicate merge
  logic [DATA_W-1:0] merged;
  for (genvar j = 0; j < N_NARROW; j++) begin : g_mg
    assign merged[j*NARROW_W +: NARROW_W] = enS3[j] ?
      sS3[j*NARROW_W +: NARROW_W] : dS3[j*NARROW_W +: NARROW_W];
  end

  // stage 4 register: output
  always_ff @(posedge clk) begin
    if (ctrl.load[3]) resData <= merged;
  end
endmodule

// File: rtl/simd_fma_unit.sv
module simd_fma_unit
  import simd_fma_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         widthSel,
  input  logic [1:0]   formSel,
  input  logic [511:0] opDst,
  input  logic [511:0] opSrc2,
  input  logic [511:0] opSrc3,
  input  logic [15:0]  laneMask,
  output logic         outValid,
  output logic [511:0] outData
);
  pipe_ctrl_t ctrl;

  simd_fma_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  simd_fma_datapath dp_i (
    .clk      (clk),
    .ctrl     (ctrl),
    .widthSel (widthSel),
    .formSel  (formSel),
    .opDst    (opDst),
    .opSrc2   (opSrc2),
    .opSrc3   (opSrc3),
    .laneMask (laneMask),
    .resData  (outData)
  );

  assign outValid = ctrl.fire;
endmodule

// File: rtl/simd_fma_chk.sv
module simd_fma_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         widthSel,
  input logic [1:0]   formSel,
  input logic [511:0] opDst,
  input logic [511:0] opSrc2,
  input logic [511:0] opSrc3,
  input logic [15:0]  laneMask,
  input logic         outValid,
  input logic [511:0] outData
);
  p_issue_to_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##4 outValid);
  p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##4 !outValid);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !outValid);

  p_form2_lane0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(widthSel, 4) && $past(formSel, 4) == 2'd2 && $past(laneMask[0], 4))
    |-> outData[31:0] == 32'($past(opSrc2[31:0], 4) * $past(opSrc3[31:0], 4)
                             + $past(opDst[31:0], 4)));

  for (genvar i = 0; i < 16; i++) begin : g_n
    p_masked_narrow_r8: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !$past(widthSel, 4) && !$past(laneMask[i], 4))
      |-> outData[i*32 +: 32] == $past(opDst[i*32 +: 32], 4));
  end
  for (genvar k = 0; k < 8; k++) begin : g_w
    p_masked_wide_r9: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && $past(widthSel, 4) && !$past(laneMask[k], 4))
      |-> outData[k*64 +: 64] == $past(opDst[k*64 +: 64], 4));
  end
endmodule

bind simd_fma_unit simd_fma_chk chk_i (.*);

// File: tb/simd_fma_unit_tb_top.sv
module simd_fma_unit_tb_top;
  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0, widthSel = 0;
  logic [1:0] formSel = 0;
  logic [511:0] opDst = 0, opSrc2 = 0, opSrc3 = 0;
  logic [15:0] laneMask = 0;
  logic outValid;
  logic [511:0] outData;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_fma_unit dut_i (.*);

  function automatic logic [511:0] model(logic [511:0] d, logic [511:0] s2,
      logic [511:0] s3, logic [15:0] m, logic w, logic [1:0] f);
    logic [511:0] r;
    logic [63:0] a, b, c;
    r = d;
    for (int i = 0; i < (w ? 8 : 16); i++) begin
      if (w) begin
        case (f)
          2'd1: begin a = s2[i*64+:64]; b = d[i*64+:64];  c = s3[i*64+:64]; end
          2'd2: begin a = s2[i*64+:64]; b = s3[i*64+:64]; c = d[i*64+:64];  end
          default: begin a = d[i*64+:64]; b = s3[i*64+:64]; c = s2[i*64+:64]; end
        endcase
        if (m[i]) r[i*64+:64] = a * b + c;
      end else begin
        case (f)
          2'd1: begin a = {32'd0, s2[i*32+:32]}; b = {32'd0, d[i*32+:32]};  c = {32'd0, s3[i*32+:32]}; end
          2'd2: begin a = {32'd0, s2[i*32+:32]}; b = {32'd0, s3[i*32+:32]}; c = {32'd0, d[i*32+:32]};  end
          default: begin a = {32'd0, d[i*32+:32]}; b = {32'd0, s3[i*32+:32]}; c = {32'd0, s2[i*32+:32]}; end
        endcase
        if (m[i]) r[i*32+:32] = 32'(a * b + c);
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32+:32] = $urandom;
    return v;
  endfunction

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // issue one op at a negedge, return at the negedge after the 4th edge
  task automatic runOne(string req, logic [511:0] d, logic [511:0] s2,
      logic [511:0] s3, logic [15:0] m, logic w, logic [1:0] f);
    opDst = d; opSrc2 = s2; opSrc3 = s3; laneMask = m; widthSel = w; formSel = f;
    inValid = 1;
    @(negedge clk);
    inValid = 0;
    repeat (3) @(negedge clk);
    checkBit({req, " valid"}, outValid, 1'b1);
    check(req, outData, model(d, s2, s3, m, w, f));
    @(negedge clk);
  endtask

  task automatic t_reset();
    checkBit("R1 reset", outValid, 1'b0);
  endtask

  task automatic t_latency();
    opDst = rnd512(); inValid = 1;
    @(negedge clk); inValid = 0;
    @(negedge clk); @(negedge clk);
    checkBit("R1 not early", outValid, 1'b0);
    @(negedge clk);
    checkBit("R1 on time", outValid, 1'b1);
    @(negedge clk);
    checkBit("R1 single pulse", outValid, 1'b0);
  endtask

  task automatic t_forms();
    for (int f = 0; f < 4; f++) begin
      runOne(f == 0 ? "R4 R2" : f == 1 ? "R5 R2" : f == 2 ? "R6 R2" : "R7 R2",
             rnd512(), rnd512(), rnd512(), 16'hFFFF, 1'b0, 2'(f));
      runOne(f == 0 ? "R4 R3" : f == 1 ? "R5 R3" : f == 2 ? "R6 R3" : "R7 R3",
             rnd512(), rnd512(), rnd512(), 16'h00FF, 1'b1, 2'(f));
    end
  endtask

  task automatic t_wrap();
    // all ones: (-1)*(-1)+(-1) = 0 per lane, no carry between lanes
    runOne("R2 wrap", {512{1'b1}}, {512{1'b1}}, {512{1'b1}}, 16'hFFFF, 1'b0, 2'd0);
    check("R2 wrap value", outData, 512'd0);
    runOne("R3 wrap", {512{1'b1}}, {512{1'b1}}, {512{1'b1}}, 16'h00FF, 1'b1, 2'd2);
    check("R3 wrap value", outData, 512'd0);
  endtask

  task automatic t_mask();
    logic [511:0] d;
    d = rnd512();
    runOne("R8 partial", d, rnd512(), rnd512(), 16'hA5C3, 1'b0, 2'd1);
    runOne("R8 none", d, rnd512(), rnd512(), 16'h0000, 1'b0, 2'd2);
    check("R8 none passthrough", outData, d);
    runOne("R9 partial", rnd512(), rnd512(), rnd512(), 16'h0036, 1'b1, 2'd0);
    // upper mask bits set with lower clear: result must equal dst
    runOne("R9 upper ignored", d, rnd512(), rnd512(), 16'hFF00, 1'b1, 2'd2);
    check("R9 upper passthrough", outData, d);
  endtask

  task automatic t_stream();
    localparam int N = 8;
    logic [511:0] ed[N];
    for (int c = 0; c < N + 5; c++) begin
      if (c >= 4 && c - 4 < N) begin
        checkBit("R10 stream valid", outValid, 1'b1);
        check("R10 stream data", outData, ed[c-4]);
      end
      if (c < N) begin
        opDst = rnd512(); opSrc2 = rnd512(); opSrc3 = rnd512();
        laneMask = 16'($urandom); widthSel = c[0]; formSel = 2'(c % 3);
        ed[c] = model(opDst, opSrc2, opSrc3, laneMask, widthSel, formSel);
        inValid = 1;
      end else inValid = 0;
      @(negedge clk);
    end
    checkBit("R10 stream end", outValid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_forms();
    t_wrap();
    t_mask();
    t_stream();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule